// File: doc/BRIEF.md
# Masked Write-One-to-Clear Interrupt Controller

This block gathers up to 27 interrupt sources into one sticky status register. Sources include inbound and outbound descriptor-chain events, an out-of-descriptors event, an external bus interrupt line and a bus-abort event. A per-source mask register and a single global enable bit gate the sticky status onto one level-sensitive interrupt line toward the CPU. Software acknowledges a source by writing a one to its status bit.

Next to the line, the block presents a 5-bit vector naming the lowest-numbered source that is both pending and unmasked, with a valid flag. A handler can therefore service sources in ascending bit order without scanning. Register access uses a plain address/data port. Reads are combinational. Writes take effect at the next rising clock edge.

Only eleven bit positions carry sources:
- bits 0–3: inbound completed, ok, error and end-of-list;
- bits 4–7: the same four events for outbound;
- bit 9: inbound out-of-descriptors;
- bit 25: external interrupt line;
- bit 26: bus abort.

Every other position is permanently zero.

Top module: `irq_gather_ctrl`

## Requirements
- R1: After reset the status, mask and enable registers all read zero, `irqOut` is 0, `irqVecValid` is 0 and `irqVec` is 0.
- R2: A source input that is high at a rising edge sets its status bit, provided the position is one of 0–7, 9, 25 or 26. The bit stays set after the input drops. A source held high keeps its bit set even across acknowledge writes.
- R3: Status positions 8 and 10–24 never become set, whatever their source inputs do, and always read as zero.
- R4: A write to offset 0x500 clears every status bit whose data bit is 1 and leaves bits written 0 unchanged.
- R5: When a source event and an acknowledge of the same bit fall in the same cycle, the bit ends up set. Other bits acknowledged in that write still clear.
- R6: Offset 0x504 holds the mask. Bits 26:0 are writable and read back in the cycle after the write. Bits 31:27 read as zero.
- R7: Offset 0x508 holds the global enable in bit 0. Only bit 0 is stored, and bits 31:1 read zero.
- R8: `irqOut` is 1 exactly when `status & mask` is non-zero and the enable bit is 1.
- R9: `irqVec` gives the index of the lowest set bit of `status & mask`. `irqVecValid` is high whenever that set is non-empty, whatever the enable bit. With nothing pending, `irqVec` is 0.
- R10: Reads of any other offset return zero. Writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| srcIn | input | 27 | Source event/level inputs, one per status position |
| regAddr | input | 12 | Register byte offset |
| regWrEn | input | 1 | Write strobe for the current cycle |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| irqOut | output | 1 | Level interrupt to the CPU |
| irqVec | output | 5 | Lowest pending unmasked source index |
| irqVecValid | output | 1 | High when any unmasked source is pending |

## Verification
The bench uses the default parameters: 27 sources, a 12-bit offset and a 32-bit data word. Both ends of the priority range, bit 0 and bit 26, can therefore be reached. So can the sparse gap between bit 9 and bit 25, where implemented and absent positions sit side by side. The vector table drives mixed bursts through varying masks and enable settings. Directed cases cover:
- the same-cycle collision between an event and an acknowledge;
- a held level source;
- writes to unmapped offsets.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_STATUS,
    RD_MASK,
    RD_ENABLE
  } rdSel_e;

  typedef struct packed {
    logic   wrStatus;
    logic   wrMask;
    logic   wrEnable;
    rdSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/irq_gather_decode.sv
module irq_gather_decode
  import irq_gather_pkg::*;
#(
  parameter int              ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] STAT_OFS = 12'h500,
  parameter logic [ADDR_W-1:0] MASK_OFS = 12'h504,
  parameter logic [ADDR_W-1:0] EN_OFS   = 12'h508
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStrobe_t        strobe
);

  always_comb begin
    strobe = '0;
    strobe.rdSel = RD_NONE;
    unique case (regAddr)
      STAT_OFS: begin
        strobe.rdSel    = RD_STATUS;
        strobe.wrStatus = regWrEn;
      end
      MASK_OFS: begin
        strobe.rdSel  = RD_MASK;
        strobe.wrMask = regWrEn;
      end
      EN_OFS: begin
        strobe.rdSel    = RD_ENABLE;
        strobe.wrEnable = regWrEn;
      end
      default: ;
    endcase
  end

  // R10: at most one register written per cycle, and only under the strobe
  assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.wrStatus, strobe.wrMask, strobe.wrEnable}));
  assert_write_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !regWrEn |-> !(strobe.wrStatus || strobe.wrMask || strobe.wrEnable));

endmodule

// File: rtl/irq_gather_prio.sv
module irq_gather_prio #(
  parameter int NUM_SRC = 27,
  parameter int VEC_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] pend,
  output logic [VEC_W-1:0]   vec,
  output logic               vecValid
);

  always_comb begin
    vec = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i]) vec = VEC_W'(i);
    end
  end

  assign vecValid = |pend;

endmodule

// File: rtl/irq_gather_core.sv
module irq_gather_core
  import irq_gather_pkg::*;
#(
  parameter int                 NUM_SRC  = 27,
  parameter int                 DATA_W   = 32,
  parameter int                 VEC_W    = $clog2(NUM_SRC),
  parameter logic [NUM_SRC-1:0] SRC_IMPL = 27'h600_02FF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  regStrobe_t         strobe,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               irqOut,
  output logic [VEC_W-1:0]   irqVec,
  output logic               irqVecValid
);

  localparam int PAD_W = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] status, mask, pend, setVec, clrVec;
  logic               globalEn;

  assign setVec = srcIn & SRC_IMPL;
  assign clrVec = strobe.wrStatus ? regWrData[NUM_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status   <= '0;
      mask     <= '0;
      globalEn <= 1'b0;
    end else begin
      status <= (status & ~clrVec) | setVec;
      if (strobe.wrMask)   mask     <= regWrData[NUM_SRC-1:0];
      if (strobe.wrEnable) globalEn <= regWrData[0];
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      logic unusedHighBits;
      assign unusedHighBits = ^regWrData[DATA_W-1:NUM_SRC];
    end
  endgenerate

  assign pend = status & mask;

  irq_gather_prio #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) i_prio (
    .pend    (pend),
    .vec     (irqVec),
    .vecValid(irqVecValid)
  );

  assign irqOut = irqVecValid & globalEn;

  always_comb begin
    regRdData = '0;
    unique case (strobe.rdSel)
      RD_STATUS: regRdData[NUM_SRC-1:0] = status;
      RD_MASK:   regRdData[NUM_SRC-1:0] = mask;
      RD_ENABLE: regRdData[0]           = globalEn;
      default:   ;
    endcase
  end

  // R3: absent positions never hold a one
  assert_sparse_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~SRC_IMPL) == '0);
  // R4: acknowledged bits with no competing event are clear next cycle
  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status & $past(clrVec & ~setVec)) == '0);
  // R5: an event always lands, even against an acknowledge
  assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status & $past(setVec)) == $past(setVec));
  // R8: line only with enable and a pending bit
  assert_line_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> (globalEn && pend != '0));
  // R9: vector names a pending bit with none below it
  assert_vec_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irqVecValid |-> (pend[irqVec] &&
      ((pend & ((NUM_SRC'(1) << irqVec) - NUM_SRC'(1))) == '0)));
  assert_vec_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irqVecValid |-> (irqVec == '0 && !irqOut));

endmodule

// File: rtl/irq_gather_ctrl.sv
module irq_gather_ctrl
  import irq_gather_pkg::*;
#(
  parameter int                 NUM_SRC  = 27,
  parameter int                 ADDR_W   = 12,
  parameter int                 DATA_W   = 32,
  parameter logic [NUM_SRC-1:0] SRC_IMPL = 27'h600_02FF,
  localparam int                VEC_W    = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               irqOut,
  output logic [VEC_W-1:0]   irqVec,
  output logic               irqVecValid
);

  regStrobe_t strobe;

  irq_gather_decode #(
    .ADDR_W  (ADDR_W),
    .STAT_OFS(ADDR_W'(12'h500)),
    .MASK_OFS(ADDR_W'(12'h504)),
    .EN_OFS  (ADDR_W'(12'h508))
  ) i_decode (
    .clk    (clk),
    .rst_n  (rst_n),
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .strobe (strobe)
  );

  irq_gather_core #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .VEC_W   (VEC_W),
    .SRC_IMPL(SRC_IMPL)
  ) i_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .srcIn      (srcIn),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .irqOut     (irqOut),
    .irqVec     (irqVec),
    .irqVecValid(irqVecValid)
  );

endmodule

// File: tb/test_irq_gather_ctrl.sv
module test_irq_gather_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NT = 6;
  localparam logic [11:0] A_STAT = 12'h500;
  localparam logic [11:0] A_MASK = 12'h504;
  localparam logic [11:0] A_EN   = 12'h508;

  localparam logic [31:0] SRC_T  [NT] = '{32'h0000_0001, 32'h0600_0000, 32'h0000_02F0,
                                          32'h07FF_FFFF, 32'h0000_0100, 32'h0000_00C8};
  localparam logic [31:0] MASK_T [NT] = '{32'h07FF_FFFF, 32'h0400_0000, 32'h0000_0200,
                                          32'h0000_0000, 32'h07FF_FFFF, 32'h0000_00C0};
  localparam logic        EN_T   [NT] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [31:0] STAT_T [NT] = '{32'h0000_0001, 32'h0600_0000, 32'h0000_02F0,
                                          32'h0600_02FF, 32'h0000_0000, 32'h0000_00C8};

  logic        clk = 0;
  logic        rst_n = 0;
  logic [26:0] srcIn = '0;
  logic [11:0] regAddr = '0;
  logic        regWrEn = 0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;
  logic [4:0]  irqVec;
  logic        irqVecValid;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_gather_ctrl i_irq_gather_ctrl (
    .clk(clk), .rst_n(rst_n), .srcIn(srcIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut), .irqVec(irqVec), .irqVecValid(irqVecValid)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rdReg(logic [11:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic pulse(logic [26:0] v);
    @(negedge clk);
    srcIn = v;
    @(negedge clk);
    srcIn = '0;
  endtask

  function automatic int lowest(logic [31:0] p);
    for (int i = 0; i < 32; i++) if (p[i]) return i;
    return 0;
  endfunction

  task automatic finish();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish();
    end
  end

  initial begin
    logic [31:0] d, pend;
    repeat (3) @(negedge clk);
    // R1 reset state
    rdReg(A_STAT, d); check("R1 status", d, 0);
    rdReg(A_MASK, d); check("R1 mask", d, 0);
    rdReg(A_EN, d);   check("R1 enable", d, 0);
    check("R1 irq/valid/vec", {irqOut, irqVecValid, irqVec}, 0);
    @(negedge clk); rst_n = 1;

    // Table walk: R2 R3 R8 R9
    for (int k = 0; k < NT; k++) begin
      wrReg(A_STAT, 32'hFFFF_FFFF);
      wrReg(A_MASK, MASK_T[k]);
      wrReg(A_EN, {31'b0, EN_T[k]});
      pulse(SRC_T[k][26:0]);
      rdReg(A_STAT, d);
      check($sformatf("R2/R3 status entry %0d", k), d, STAT_T[k]);
      pend = STAT_T[k] & MASK_T[k];
      check($sformatf("R8 irqOut entry %0d", k), irqOut, (pend != 0) && EN_T[k]);
      check($sformatf("R9 valid entry %0d", k), irqVecValid, pend != 0);
      check($sformatf("R9 vec entry %0d", k), irqVec, lowest(pend));
    end

    // R4 partial acknowledge
    wrReg(A_STAT, 32'hFFFF_FFFF);
    pulse(27'h3);
    wrReg(A_STAT, 32'h1);
    rdReg(A_STAT, d); check("R4 clear one", d, 32'h2);
    wrReg(A_STAT, 32'h0);
    rdReg(A_STAT, d); check("R4 zero write keeps", d, 32'h2);

    // R5 event vs acknowledge same cycle
    @(negedge clk);
    srcIn = 27'h4; regAddr = A_STAT; regWrData = 32'h6; regWrEn = 1;
    @(negedge clk);
    srcIn = '0; regWrEn = 0;
    rdReg(A_STAT, d); check("R5 event wins", d, 32'h4);

    // R2 held level on bit 25
    wrReg(A_STAT, 32'hFFFF_FFFF);
    @(negedge clk); srcIn = 27'h200_0000;
    wrReg(A_STAT, 32'h0200_0000);
    rdReg(A_STAT, d); check("R2 held level stays", d, 32'h0200_0000);
    srcIn = '0;
    wrReg(A_STAT, 32'h0200_0000);
    rdReg(A_STAT, d); check("R2 released then cleared", d, 0);

    // R6 mask width
    wrReg(A_MASK, 32'hFFFF_FFFF);
    rdReg(A_MASK, d); check("R6 mask readback", d, 32'h07FF_FFFF);

    // R7 enable width and effect on line (R8)
    wrReg(A_EN, 32'hFFFF_FFFF);
    rdReg(A_EN, d); check("R7 enable readback", d, 32'h1);
    pulse(27'h400_0000);
    check("R8 line on", irqOut, 1);
    check("R9 vec 26", irqVec, 26);
    wrReg(A_EN, 32'h0);
    check("R8 line off when disabled", irqOut, 0);
    check("R9 valid without enable", irqVecValid, 1);

    // R10 unmapped offset
    wrReg(12'h50C, 32'hFFFF_FFFF);
    rdReg(12'h50C, d); check("R10 unmapped read", d, 0);
    rdReg(A_STAT, d);  check("R10 status untouched", d, 32'h0400_0000);
    rdReg(A_MASK, d);  check("R10 mask untouched", d, 32'h07FF_FFFF);
    rdReg(A_EN, d);    check("R10 enable untouched", d, 0);

    finished = 1;
    finish();
  end

endmodule